// File: doc/BRIEF.md
# Write-to-Acknowledge Interrupt Status Register

This block is the interrupt status and control word of a packet peripheral. It holds three flags: transmit-complete, receive-complete and a software test flag. The packet data path raises the two completion flags with single-cycle set pulses. The host clears them by writing the register, and it can also raise the test flag this way to check the interrupt wiring.

A host write acts on one bit only, chosen by priority. Bit 0 is considered first, then bit 1, then bit 31. The test flag is set by a write and is cleared as a side effect of a host read. A level interrupt line is high while any flag is set. A busy status bit is refreshed from the flag state on every host write and keeps its value between writes.

The read word is presented combinationally from the flag register. A read strobe therefore sees the flags that are current in that cycle, and the test flag clears at the clock edge that ends the read.

Top module: `irq_ack_reg`

## Requirements
- R1: A synchronous active-high reset clears all three flags, `irq_o` and `busy_o`. The read word is then zero.
- R2: A pulse on `tx_done_set` or `rx_done_set` sets the flag at the next clock edge. The transmit flag appears at read-word bit 0 and the receive flag at bit 1. Every other read-word bit except bit 31 reads zero.
- R3: `irq_o` is high exactly when at least one flag is set. It follows a flag change in the same cycle as the read word.
- R4: A host write whose data has bit 0 set clears only the transmit flag. Data bits 1 and 31 in that write have no effect.
- R5: A host write with bit 0 clear and bit 1 set clears only the receive flag. Data bit 31 in that write has no effect.
- R6: A host write with bits 0 and 1 clear and bit 31 set sets the test flag, which appears at read-word bit 31.
- R7: A host write with none of bits 0, 1 or 31 set leaves all flags unchanged.
- R8: A host read returns the current flags and clears the test flag at the end of that read cycle. The transmit and receive flags are not affected.
- R9: After each host write, `busy_o` equals the OR of the flags as they stand after that write. Without a write, `busy_o` holds its value.
- R10: If a set pulse and a host clear target the same flag in one cycle, the flag ends up set.
- R11: If a test-setting write and a read occur in the same cycle, the test flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for this register |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe for this register |
| host_rdata | output | 32 | Current flag word (bit 0 transmit, bit 1 receive, bit 31 test) |
| tx_done_set | input | 1 | Transmit-complete set pulse from the data path |
| rx_done_set | input | 1 | Receive-complete set pulse from the data path |
| irq_o | output | 1 | Level interrupt, high while any flag is set |
| busy_o | output | 1 | Busy status, refreshed on each host write |

## Verification
Every result of this block is due one clock edge after its stimulus. A set pulse, a write or a read changes the flag word and `irq_o` at the next edge, and a write changes `busy_o` at that same edge. The bench drives inputs on the falling edge and samples exactly one falling edge later, so each check looks at the cycle in which the change is due. It sweeps all eight starting flag states against all sixteen combinations of write bits 0, 1, 31 and an unrelated bit, and computes each expected word from the priority rule. Directed cases then cover read clearing, busy holding between writes, and the two same-cycle collisions.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int WORD_W   = 32;
    localparam int TX_POS   = 0;
    localparam int RX_POS   = 1;
    localparam int TEST_POS = WORD_W - 1;

    typedef struct packed {
        logic test;
        logic rx;
        logic tx;
    } flags_t;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_CLR_TX   = 2'd1,
        OP_CLR_RX   = 2'd2,
        OP_SET_TEST = 2'd3
    } wr_op_e;

    // Priority decode: lowest significant control bit wins.
    function automatic wr_op_e decode_write(input logic [WORD_W-1:0] d);
        wr_op_e op;
        if (d[TX_POS])        op = OP_CLR_TX;
        else if (d[RX_POS])   op = OP_CLR_RX;
        else if (d[TEST_POS]) op = OP_SET_TEST;
        else                  op = OP_NONE;
        return op;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input flags_t f);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[TX_POS]   = f.tx;
        w[RX_POS]   = f.rx;
        w[TEST_POS] = f.test;
        return w;
    endfunction

    function automatic logic any_flag(input flags_t f);
        return f.tx | f.rx | f.test;
    endfunction

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_ack_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output wr_op_e            op
);

    always_comb begin
        if (wr_en) op = decode_write(wdata);
        else       op = OP_NONE;
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_ack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wr_op_e op,
    input  logic   rd_en,
    input  logic   tx_set,
    input  logic   rx_set,
    output flags_t flags_q,
    output flags_t flags_next
);

    always_comb begin
        flags_next = flags_q;
        unique case (op)
            OP_CLR_TX:   flags_next.tx   = 1'b0;
            OP_CLR_RX:   flags_next.rx   = 1'b0;
            OP_SET_TEST: flags_next.test = 1'b1;
            default:     ;
        endcase
        // A read clears the test flag unless a write raises it in the same cycle.
        if (rd_en && op != OP_SET_TEST) flags_next.test = 1'b0;
        // Data-path set events override any host clear.
        if (tx_set) flags_next.tx = 1'b1;
        if (rx_set) flags_next.rx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_next;
    end

    // R10
    tx_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        tx_set |=> flags_q.tx);

    // R10
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rx_set |=> flags_q.rx);

    // R8
    rd_clears_test_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && op != OP_SET_TEST) |=> !flags_q.test);

    // R6
    set_test_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SET_TEST) |=> flags_q.test);

endmodule

// File: rtl/irq_status_out.sv
module irq_status_out
    import irq_ack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  flags_t flags_q,
    input  flags_t flags_next,
    output logic   irq_o,
    output logic   busy_o
);

    logic busy_q;

    assign irq_o  = any_flag(flags_q);
    assign busy_o = busy_q;

    always_ff @(posedge clk) begin
        if (rst)        busy_q <= 1'b0;
        else if (wr_en) busy_q <= any_flag(flags_next);
    end

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(busy_o));

    // R9
    busy_track_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (busy_o == irq_o));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !irq_o));

endmodule

// File: rtl/irq_ack_reg.sv
module irq_ack_reg
    import irq_ack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              tx_done_set,
    input  logic              rx_done_set,
    output logic              irq_o,
    output logic              busy_o
);

    wr_op_e op;
    flags_t flags_q;
    flags_t flags_next;

    irq_wr_decode u_decode (
        .wr_en (host_wr),
        .wdata (host_wdata),
        .op    (op)
    );

    irq_flag_bank u_flags (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .rd_en      (host_rd),
        .tx_set     (tx_done_set),
        .rx_set     (rx_done_set),
        .flags_q    (flags_q),
        .flags_next (flags_next)
    );

    irq_status_out u_status (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (host_wr),
        .flags_q    (flags_q),
        .flags_next (flags_next),
        .irq_o      (irq_o),
        .busy_o     (busy_o)
    );

    assign host_rdata = pack_word(flags_q);

    // R3
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == (host_rdata != '0));

    // R4
    tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_wdata[TX_POS] && !tx_done_set) |=> !host_rdata[TX_POS]);

    // R4
    tx_clear_keeps_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_wdata[TX_POS] && !rx_done_set && !host_rd)
            |=> (host_rdata[RX_POS] == $past(host_rdata[RX_POS])
                 && host_rdata[TEST_POS] == $past(host_rdata[TEST_POS])));

endmodule

// File: tb/test_irq_ack_reg.sv
`timescale 1ns/1ps
module test_irq_ack_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        tx_done_set = 1'b0;
    logic        rx_done_set = 1'b0;
    logic        irq_o;
    logic        busy_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ack_reg i_irq_ack_reg (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rd     (host_rd),
        .host_rdata  (host_rdata),
        .tx_done_set (tx_done_set),
        .rx_done_set (rx_done_set),
        .irq_o       (irq_o),
        .busy_o      (busy_o)
    );

    // Advance one edge and land on the following falling edge.
    task automatic step();
        @(posedge clk);
        #2.5;
    endtask

    // Compares {busy, irq, word}.
    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual busy=%0b irq=%0b word=%h expected busy=%0b irq=%0b word=%h",
                     req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    function automatic logic [31:0] mk_word(input logic t, input logic r, input logic x);
        return {t, 29'd0, r, x};
    endfunction

    // Starting state: s[0]=tx, s[1]=rx, s[2]=test.
    task automatic load_state(input logic [2:0] s);
        rst = 1'b1;
        step();
        rst = 1'b0;
        tx_done_set = s[0];
        rx_done_set = s[1];
        step();
        tx_done_set = 1'b0;
        rx_done_set = 1'b0;
        if (s[2]) begin
            host_wr = 1'b1;
            host_wdata = 32'h8000_0000;
            step();
            host_wr = 1'b0;
            host_wdata = '0;
        end
    endtask

    initial begin
        step();
        step();
        // R1: reset state
        check("R1", {busy_o, irq_o, host_rdata}, 34'd0);
        rst = 1'b0;

        // R2 and R3: set pulses, busy stays 0 without a write (R9)
        tx_done_set = 1'b1;
        step();
        tx_done_set = 1'b0;
        check("R2", {busy_o, irq_o, host_rdata}, {1'b0, 1'b1, mk_word(0, 0, 1)});
        rx_done_set = 1'b1;
        step();
        rx_done_set = 1'b0;
        check("R3", {busy_o, irq_o, host_rdata}, {1'b0, 1'b1, mk_word(0, 1, 1)});

        // Sweep: 8 start states x 16 write patterns (R4 R5 R6 R7 R9)
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 16; p++) begin
                logic [2:0]  st;
                logic [31:0] wd;
                logic        et, er, ex, eb;
                string       tag;
                st = s[2:0];
                load_state(st);
                check("R6", {busy_o, irq_o, host_rdata},
                      {st[2], |st, mk_word(st[2], st[1], st[0])});
                wd = '0;
                wd[0]  = p[0];
                wd[1]  = p[1];
                wd[31] = p[2];
                wd[5]  = p[3];
                ex = st[0]; er = st[1]; et = st[2];
                if (p[0])      begin ex = 1'b0; tag = "R4"; end
                else if (p[1]) begin er = 1'b0; tag = "R5"; end
                else if (p[2]) begin et = 1'b1; tag = "R6"; end
                else           tag = "R7";
                eb = ex | er | et;
                host_wr = 1'b1;
                host_wdata = wd;
                step();
                host_wr = 1'b0;
                host_wdata = '0;
                check(tag, {busy_o, irq_o, host_rdata}, {eb, eb, mk_word(et, er, ex)});
            end
        end

        // R8: read returns flags, then clears only test
        load_state(3'b111);
        host_rd = 1'b1;
        check("R8", {1'b1, irq_o, host_rdata}, {1'b1, 1'b1, mk_word(1, 1, 1)});
        step();
        host_rd = 1'b0;
        check("R8", {busy_o, irq_o, host_rdata}, {1'b1, 1'b1, mk_word(0, 1, 1)});

        // R9: busy holds after flags clear without a write
        load_state(3'b100);
        host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        check("R9", {busy_o, irq_o, host_rdata}, {1'b1, 1'b0, 32'd0});
        host_wr = 1'b1;
        host_wdata = 32'h0000_0010;
        step();
        host_wr = 1'b0;
        check("R9", {busy_o, irq_o, host_rdata}, {1'b0, 1'b0, 32'd0});

        // R10: set pulse beats same-cycle clear
        load_state(3'b011);
        host_wr = 1'b1;
        host_wdata = 32'h0000_0001;
        tx_done_set = 1'b1;
        step();
        host_wr = 1'b0;
        tx_done_set = 1'b0;
        check("R10", {busy_o, irq_o, host_rdata}, {1'b1, 1'b1, mk_word(0, 1, 1)});
        host_wr = 1'b1;
        host_wdata = 32'h0000_0002;
        rx_done_set = 1'b1;
        step();
        host_wr = 1'b0;
        rx_done_set = 1'b0;
        check("R10", {busy_o, irq_o, host_rdata}, {1'b1, 1'b1, mk_word(0, 1, 1)});

        // R11: test-set write beats same-cycle read clear
        load_state(3'b000);
        host_wr = 1'b1;
        host_rd = 1'b1;
        host_wdata = 32'h8000_0000;
        step();
        host_wr = 1'b0;
        host_rd = 1'b0;
        check("R11", {busy_o, irq_o, host_rdata}, {1'b1, 1'b1, mk_word(1, 0, 0)});

        // R1: reset from a full state
        load_state(3'b111);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1", {busy_o, irq_o, host_rdata}, 34'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule